// File: doc/BRIEF.md
# Serial Line Transmitter with Commanded Break

This block drives an asynchronous serial output line. Characters come in through a one-entry holding register. Each character is moved into a shift register and sent as a frame, with one bit per baud-tick period. A frame is a low start bit, the data bits least significant first, an optional parity bit, and a high stop bit. Baud-rate generation is outside the block: the block only takes a one-cycle `tick` strobe from the system clock domain.

On top of normal framing, two command pulses control a break. A break holds the line low. It looks like an all-zero character whose parity and stop bits are also zero, except that it lasts as long as software keeps it. A break request waits for any character that is already on the line to finish. The break then lasts at least one full frame time, even if the release command came earlier. Extra requests made while a break is pending or running have no effect. After a break the line goes high for one bit period before anything else is sent.

The character input is a valid/ready port. A character is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when the holding register is empty. While `in_ready` is low, the source must keep `in_valid` and `in_data` stable until the transfer happens. The port may accept a character at any time, including during a break. Command pulses and writes are captured on any clock cycle. The line and the bit counting advance only on tick cycles.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` is 1, `tx_empty` is 1, and `brk_active` and `brk_pending` are 0.
- R2: A frame is sent one bit per tick: a start bit of 0, then the data bits LSB first, then a stop bit of 1. If the holding register is full when a stop bit ends, the next start bit follows with no idle bit between.
- R3: `par_mode` selects the parity: 2'b00 and 2'b11 give no parity bit (10-bit frame), 2'b01 gives even parity and 2'b10 gives odd parity. The parity bit sits right after the last data bit (11-bit frame).
- R4: `in_ready` is 1 exactly when the holding register is empty. An accepted character stays in the holding register, and `in_ready` stays 0, until the shifter takes that character.
- R5: A break request latches `brk_pending`. If the line is idle, the next tick drives `txd` to 0 and raises `brk_active`.
- R6: If a release command arrives before the minimum time has passed, the break lasts exactly one frame time: 10 bit periods without parity and 11 with parity.
- R7: Without a release command the break holds `txd` low for as long as it lasts. A release command given while no break is pending or running is ignored.
- R8: A break requested while a character is being shifted out starts on the tick right after that character's stop bit. The character is not cut short.
- R9: Break requests that arrive while a break is pending or running are ignored. One break is produced per accepted request.
- R10: When a break ends, `txd` is 1 for one bit period. A character accepted during the break is kept and starts right after that one-bit mark.
- R11: `txd` and the shifter state change only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle baud strobe; one bit period per strobe |
| par_mode | input | 2 | Parity select: 00/11 none, 01 even, 10 odd |
| in_valid | input | 1 | Character offered on `in_data` |
| in_ready | output | 1 | Holding register empty, character will be accepted |
| in_data | input | 8 | Character to transmit |
| brk_start | input | 1 | Pulse: request a break |
| brk_stop | input | 1 | Pulse: request release of the break |
| txd | output | 1 | Serial output line, idle high |
| tx_empty | output | 1 | Shifter idle and holding register empty |
| brk_active | output | 1 | Break currently driving the line low |
| brk_pending | output | 1 | Break requested and not yet ended |

## Verification
Back-to-back character bursts are sent in every parity mode, with the all-zero and all-one bytes among them. These tell the frame length, the bit order, the parity sense and the absence of idle bits apart. Breaks are tried from idle with an early release, in the middle of a character, with a character written during the break, and held long with a repeated request. These separate the minimum-length rule, the wait for the in-flight character, the one-bit mark and the ignored commands. The line is captured once per tick and decoded in the bench: a low run at least one frame long counts as a break, and any other low bit starts a frame. Random bursts with a fixed seed follow the directed cases.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

  typedef enum logic [1:0] {
    PAR_NONE   = 2'b00,
    PAR_EVEN   = 2'b01,
    PAR_ODD    = 2'b10,
    PAR_NONE_X = 2'b11
  } par_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_BREAK = 2'b10,
    ST_MARK  = 2'b11
  } tx_st_e;

endpackage

// File: rtl/uart_frame_build.sv
module uart_frame_build
  import uart_brk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 3,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [1:0]         par_mode_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);

  localparam int BASE_BITS = DATA_W + 2;

  par_e mode;
  logic use_par;
  logic par_bit;

  assign mode = par_e'(par_mode_i);

  // parity selection: even makes total ones even, odd makes it odd
  always_comb begin
    case (mode)
      PAR_EVEN: begin use_par = 1'b1; par_bit = ^data_i;  end
      PAR_ODD:  begin use_par = 1'b1; par_bit = ~^data_i; end
      default:  begin use_par = 1'b0; par_bit = 1'b0;     end
    endcase
  end

  // frame laid out LSB first: start, data, [parity], stop, pad ones
  always_comb begin
    frame_o             = '1;
    frame_o[0]          = 1'b0;
    frame_o[DATA_W:1]   = data_i;
    if (use_par) frame_o[DATA_W+1] = par_bit;
  end

  assign nbits_o = CNT_W'(BASE_BITS) + CNT_W'(use_par);

endmodule

// File: rtl/uart_hold_reg.sv
module uart_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              take_i,
  output logic              hold_valid_o,
  output logic [DATA_W-1:0] hold_data_o
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign in_ready_o   = ~valid_q;
  assign accept       = in_valid_i & ~valid_q;
  assign hold_valid_o = valid_q;
  assign hold_data_o  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      data_q  <= in_data_i;
    end else if (take_i) begin
      valid_q <= 1'b0;
    end
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !take_i) |=> (valid_q && $stable(data_q))); // R4

  AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> valid_q); // R10

endmodule

// File: rtl/uart_brk_ctrl.sv
module uart_brk_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_start_i,
  input  logic brk_stop_i,
  input  logic brk_done_i,
  output logic brk_req_o,
  output logic stop_seen_o
);

  logic req_q;
  logic stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      stop_q <= 1'b0;
    end else if (brk_done_i) begin
      // commands coinciding with the end of a break are dropped
      req_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (brk_start_i) req_q <= 1'b1;
      if (brk_stop_i && (req_q || brk_start_i)) stop_q <= 1'b1;
    end
  end

  assign brk_req_o   = req_q;
  assign stop_seen_o = stop_q;

  AST_STOP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> req_q); // R7

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !brk_done_i) |=> req_q); // R9

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_brk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 3,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               hold_valid_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               brk_req_i,
  input  logic               stop_seen_i,
  output logic               take_o,
  output logic               brk_done_o,
  output logic               txd_o,
  output logic               brk_active_o,
  output logic               idle_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  tx_st_e             state_q, state_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   len_q, len_d;
  logic               txd_q, txd_d;
  logic               pick;

  always_comb begin
    state_d    = state_q;
    sh_d       = sh_q;
    cnt_d      = cnt_q;
    len_d      = len_q;
    txd_d      = txd_q;
    take_o     = 1'b0;
    brk_done_o = 1'b0;
    pick       = 1'b0;

    if (tick_i) begin
      case (state_q)
        ST_IDLE:  pick = 1'b1;
        ST_SHIFT: begin
          if (cnt_q == len_q) begin
            pick = 1'b1;
          end else begin
            txd_d = sh_q[0];
            sh_d  = sh_q >> 1;
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        ST_BREAK: begin
          if (cnt_q != len_q) begin
            cnt_d = cnt_q + CNT_ONE;
          end else if (stop_seen_i) begin
            state_d    = ST_MARK;
            txd_d      = 1'b1;
            brk_done_o = 1'b1;
          end
        end
        default:  pick = 1'b1;
      endcase

      // choose the next line activity: break first, then a waiting character
      if (pick) begin
        if (brk_req_i) begin
          state_d = ST_BREAK;
          txd_d   = 1'b0;
          cnt_d   = CNT_ONE;
          len_d   = nbits_i;
        end else if (hold_valid_i) begin
          state_d = ST_SHIFT;
          take_o  = 1'b1;
          txd_d   = frame_i[0];
          sh_d    = frame_i >> 1;
          cnt_d   = CNT_ONE;
          len_d   = nbits_i;
        end else begin
          state_d = ST_IDLE;
          txd_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '1;
      cnt_q   <= '0;
      len_q   <= '0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      txd_q   <= txd_d;
    end
  end

  assign txd_o        = txd_q;
  assign brk_active_o = (state_q == ST_BREAK);
  assign idle_o       = (state_q == ST_IDLE);

  AST_BRK_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active_o |-> !txd_o); // R5

  AST_BRK_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_active_o) |-> ($past(cnt_q) == $past(len_q))); // R6

  AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active_o && !stop_seen_i) |=> brk_active_o); // R7

  AST_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && cnt_q != len_q) |=> (state_q == ST_SHIFT)); // R8

  AST_MARK_AFTER_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_active_o) |-> txd_o); // R10

  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(txd_q) && $stable(state_q) && $stable(cnt_q))); // R11

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        par_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              brk_start,
  input  logic              brk_stop,
  output logic              txd,
  output logic              tx_empty,
  output logic              brk_active,
  output logic              brk_pending
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               hold_valid;
  logic [DATA_W-1:0]  hold_data;
  logic               take;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               brk_req;
  logic               stop_seen;
  logic               brk_done;
  logic               sh_idle;

  uart_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid_i   (in_valid),
    .in_ready_o   (in_ready),
    .in_data_i    (in_data),
    .take_i       (take),
    .hold_valid_o (hold_valid),
    .hold_data_o  (hold_data)
  );

  uart_frame_build #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_frame (
    .data_i     (hold_data),
    .par_mode_i (par_mode),
    .frame_o    (frame),
    .nbits_o    (nbits)
  );

  uart_brk_ctrl u_brk (
    .clk         (clk),
    .rst_n       (rst_n),
    .brk_start_i (brk_start),
    .brk_stop_i  (brk_stop),
    .brk_done_i  (brk_done),
    .brk_req_o   (brk_req),
    .stop_seen_o (stop_seen)
  );

  uart_tx_shift #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .hold_valid_i (hold_valid),
    .frame_i      (frame),
    .nbits_i      (nbits),
    .brk_req_i    (brk_req),
    .stop_seen_i  (stop_seen),
    .take_o       (take),
    .brk_done_o   (brk_done),
    .txd_o        (txd),
    .brk_active_o (brk_active),
    .idle_o       (sh_idle)
  );

  assign tx_empty    = sh_idle & ~hold_valid;
  assign brk_pending = brk_req;

endmodule

// File: tb/uart_brk_tx_tb.sv
module uart_brk_tx_tb;

  localparam int DW    = 8;
  localparam int LMAX  = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [1:0]    par_mode = 2'b00;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          brk_start = 1'b0;
  logic          brk_stop = 1'b0;
  logic          txd;
  logic          tx_empty;
  logic          brk_active;
  logic          brk_pending;

  int n_checks = 0;
  int n_err    = 0;

  logic line_q [0:LMAX-1];
  int   nline = 0;
  int   r11_bad = 0;
  logic last_txd = 1'b1;

  int   exp_kind [0:63];
  int   exp_data [0:63];
  int   exp_len  [0:63];
  int   exp_gap  [0:63];
  int   n_exp = 0;

  uart_brk_tx #(.DATA_W(DW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .par_mode    (par_mode),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .brk_start   (brk_start),
    .brk_stop    (brk_stop),
    .txd         (txd),
    .tx_empty    (tx_empty),
    .brk_active  (brk_active),
    .brk_pending (brk_pending)
  );

  always #4 clk = ~clk;

  // baud strobe: one cycle in four
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // line capture once per tick; between ticks the line must not move (R11)
  initial begin
    forever begin
      @(posedge clk);
      if (tick) begin
        @(negedge clk);
        if (nline < LMAX) line_q[nline] = txd;
        nline++;
        last_txd = txd;
      end else begin
        @(negedge clk);
        if (rst_n && txd !== last_txd) r11_bad++;
        last_txd = txd;
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int has_par(input logic [1:0] pm);
    return (pm == 2'b01 || pm == 2'b10) ? 1 : 0;
  endfunction

  function automatic int frame_bits(input logic [1:0] pm);
    return DW + 2 + has_par(pm);
  endfunction

  function automatic int exp_par(input int d, input logic [1:0] pm);
    logic [DW-1:0] b;
    b = DW'(d);
    return (pm == 2'b01) ? int'(^b) : int'(~^b);
  endfunction

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!tick);
    end
    @(negedge clk);
  endtask

  task automatic send(input int d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(d);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    brk_start = 1'b1;
    @(negedge clk);
    brk_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    brk_stop = 1'b1;
    @(negedge clk);
    brk_stop = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(tx_empty && !brk_pending)) @(negedge clk);
    wait_ticks(2);
  endtask

  task automatic begin_capture();
    @(negedge clk);
    nline = 0;
    n_exp = 0;
  endtask

  task automatic add_exp(input int kind, input int d, input int len, input int gap);
    exp_kind[n_exp] = kind;
    exp_data[n_exp] = d;
    exp_len[n_exp]  = len;
    exp_gap[n_exp]  = gap;
    n_exp++;
  endtask

  // kind 0 = character, 1 = break; len > 0 exact, len < 0 means at least -len
  task automatic decode(input logic [1:0] pm, input string req);
    int i;
    int e;
    int ones;
    int nb;
    i = 0; e = 0; ones = 0;
    nb = frame_bits(pm);
    while (i < nline && i < LMAX) begin
      if (line_q[i]) begin
        ones++;
        i++;
      end else begin
        int z;
        int kind;
        int d;
        int p;
        int st;
        z = 0;
        while (i + z < nline && i + z < LMAX && !line_q[i+z]) z++;
        d = 0; p = 0; st = 1;
        if (z >= nb) begin
          kind = 1;
          i += z;
        end else begin
          kind = 0;
          for (int k = 0; k < DW; k++)
            if (i + 1 + k < LMAX && line_q[i+1+k]) d |= (1 << k);
          if (has_par(pm) != 0 && i + 1 + DW < LMAX) p = int'(line_q[i+1+DW]);
          if (i + nb - 1 < LMAX) st = int'(line_q[i+nb-1]);
          i += nb;
        end
        if (e >= n_exp) begin
          check(1'b0, req, "unexpected line event", kind, -1);
        end else begin
          check(kind == exp_kind[e], req, "event kind", kind, exp_kind[e]);
          if (exp_gap[e] >= 0)
            check(ones == exp_gap[e], req, "idle bits before event", ones, exp_gap[e]);
          if (kind == 1 && exp_kind[e] == 1) begin
            if (exp_len[e] > 0)
              check(z == exp_len[e], req, "break length", z, exp_len[e]);
            else
              check(z >= -exp_len[e], req, "break min length", z, -exp_len[e]);
          end else if (kind == 0 && exp_kind[e] == 0) begin
            check(d == exp_data[e], req, "data bits", d, exp_data[e]);
            check(st == 1, req, "stop bit", st, 1);
            if (has_par(pm) != 0)
              check(p == exp_par(exp_data[e], pm), req, "parity bit", p,
                    exp_par(exp_data[e], pm));
          end
        end
        e++;
        ones = 0;
      end
    end
    check(e == n_exp, req, "event count", e, n_exp);
  endtask

  task automatic burst(input logic [1:0] pm, input int cnt, input int first_d,
                       input string req);
    int d;
    @(negedge clk);
    par_mode = pm;
    begin_capture();
    for (int k = 0; k < cnt; k++) begin
      d = (k == 0) ? first_d : int'($urandom_range(0, 255));
      add_exp(0, d, 0, (k == 0) ? -1 : 0);
      send(d);
    end
    wait_idle();
    decode(pm, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R1: reset state
    check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(tx_empty == 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
    check(brk_active == 1'b0, "R1", "brk_active after reset", int'(brk_active), 0);
    check(brk_pending == 1'b0, "R1", "brk_pending after reset", int'(brk_pending), 0);
    rst_n = 1'b1;
    wait_ticks(2);

    // R2: plain frames back to back, no parity, extreme bytes included
    burst(2'b00, 4, 8'h00, "R2");
    burst(2'b11, 3, 8'hFF, "R2");
    // R3: even and odd parity
    burst(2'b01, 4, 8'h00, "R3");
    burst(2'b10, 4, 8'h00, "R3");
    burst(2'b01, 3, 8'h7F, "R3");

    // R4: holding register back-pressure
    par_mode = 2'b00;
    begin_capture();
    add_exp(0, 8'h5A, 0, -1);
    add_exp(0, 8'hC3, 0, 0);
    send(8'h5A);
    send(8'hC3);
    check(in_ready == 1'b0, "R4", "in_ready while holding full", int'(in_ready), 0);
    wait_ticks(3);
    check(in_ready == 1'b0, "R4", "in_ready stays low until taken", int'(in_ready), 0);
    check(tx_empty == 1'b0, "R4", "tx_empty while busy", int'(tx_empty), 0);
    wait_idle();
    check(in_ready == 1'b1, "R4", "in_ready after drain", int'(in_ready), 1);
    decode(2'b00, "R4");

    // R5/R6: break from idle with early release, both frame lengths
    for (int m = 0; m < 2; m++) begin
      par_mode = (m == 0) ? 2'b00 : 2'b01;
      begin_capture();
      add_exp(1, 0, frame_bits(par_mode), -1);
      pulse_start();
      check(brk_pending == 1'b1, "R5", "pending after request", int'(brk_pending), 1);
      pulse_stop();
      wait_ticks(1);
      check(brk_active == 1'b1, "R5", "break active", int'(brk_active), 1);
      check(txd == 1'b0, "R5", "line low in break", int'(txd), 0);
      wait_idle();
      decode(par_mode, "R6");
    end

    // R7/R9: ignored release at idle, long hold, repeated request
    par_mode = 2'b00;
    begin_capture();
    pulse_stop();
    pulse_start();
    wait_ticks(3);
    pulse_start();
    wait_ticks(30);
    check(brk_active == 1'b1, "R7", "break held past minimum", int'(brk_active), 1);
    check(txd == 1'b0, "R7", "line low while held", int'(txd), 0);
    add_exp(1, 0, -33, -1);
    pulse_stop();
    wait_idle();
    wait_ticks(12);
    decode(2'b00, "R9");

    // R8: request during a character
    par_mode = 2'b10;
    begin_capture();
    add_exp(0, 8'hA5, 0, -1);
    add_exp(1, 0, 11, 0);
    send(8'hA5);
    wait_ticks(3);
    pulse_start();
    pulse_stop();
    check(brk_active == 1'b0, "R8", "no break mid-character", int'(brk_active), 0);
    wait_idle();
    decode(2'b10, "R8");

    // R10: character written during a break
    par_mode = 2'b00;
    begin_capture();
    add_exp(1, 0, 10, -1);
    add_exp(0, 8'h3C, 0, 1);
    pulse_start();
    wait_ticks(2);
    send(8'h3C);
    check(in_ready == 1'b0, "R10", "character kept during break", int'(in_ready), 0);
    check(brk_active == 1'b1, "R10", "break continues after write", int'(brk_active), 1);
    pulse_stop();
    wait_idle();
    decode(2'b00, "R10");

    // random bursts, optional break afterwards
    for (int it = 0; it < 12; it++) begin
      logic [1:0] pm;
      int cnt;
      pm  = 2'($urandom_range(0, 3));
      cnt = int'($urandom_range(1, 3));
      burst(pm, cnt, int'($urandom_range(0, 255)), "R2");
      if ($urandom_range(0, 2) == 0) begin
        begin_capture();
        add_exp(1, 0, frame_bits(pm), -1);
        pulse_start();
        pulse_stop();
        wait_idle();
        decode(pm, "R6");
      end
    end

    check(r11_bad == 0, "R11", "line moves between ticks", r11_bad, 0);
    finish_run();
  end

endmodule